// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the host-facing register set for one channel of a storage bus-master DMA engine. It holds a command register with a start bit and a transfer direction bit, a status register with an active flag and an interrupt flag, and a 32-bit pointer to the descriptor table. The host reaches all of them over a simple synchronous register bus that has separate read and write strobes, a byte offset and an access size.

The block does not fetch descriptors or move data. It drives the descriptor walker's start and stop handshake. When the host raises the start bit, the block loads the walker's fetch pointer from the table base, sets the active flag and sends a one-cycle kick to the walker. When the host drops the start bit while the walker is still busy, the block lets the transfer finish and only then clears the active flag.

The drive's interrupt line passes straight through to the host interrupt. A high level on it also latches a sticky status flag, which the host clears by writing 1 to it.

Top module: `bmdma_regs`

## Requirements
- R1: A command write (offset 0) acts on the channel only when its bit 0 (start) differs from the stored start bit. Writing the same start value again gives no kick, no stop pulse and no change of the active flag.
- R2: A 0-to-1 change of start while the channel is idle does three things at the clock edge that takes the write. It sets the active flag, loads `walk_ptr_o` from the base register, and raises `walk_start_o` for exactly one cycle.
- R3: A 1-to-0 change of start clears the active flag and pulses `walk_stop_o` for one cycle. If `walk_busy_i` is high, the active flag stays set, and the clear and the pulse come at the first edge at which `walk_busy_i` is low.
- R4: A 0-to-1 change of start while the active flag is still set (a stop is pending) reloads `walk_ptr_o` from the base and cancels the pending stop. It gives no kick, and the active flag stays set after the walker goes idle.
- R5: The command register keeps only bit 0 (start) and bit 3 (direction). All other bits read back as 0, and `dir_o` follows the stored bit 3.
- R6: The base register sits at offsets 4 to 7, one byte lane per offset. A write with size code 0 (1 byte), 1 (2 bytes) or 2 (4 bytes) updates only the lanes from the addressed lane up to bit 31. Write data is taken right-aligned, and bits [1:0] of the base are always 0.
- R7: A read at offset 4 to 7 returns the base shifted right by 8 times the lane, masked to the access width.
- R8: The status register sits at offset 2, with bit 0 the active flag and bit 2 the interrupt flag. `host_irq_o` equals `drv_irq_i` in the same cycle. A high `drv_irq_i` sets the interrupt flag, and a low level leaves the flag unchanged.
- R9: Writing 1 to status bit 2 clears the interrupt flag unless `drv_irq_i` is high in that cycle. Writes to status bit 0 have no effect.
- R10: Reset clears the command, status, base and fetch pointer, and holds `walk_start_o` and `walk_stop_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Byte offset |
| reg_size_i | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| reg_wdata_i | input | 32 | Write data, right-aligned |
| reg_rdata_o | output | 32 | Read data, right-aligned; 0 when no read is in progress |
| walk_busy_i | input | 1 | Walker has a transfer in flight |
| walk_start_o | output | 1 | One-cycle kick to the walker |
| walk_stop_o | output | 1 | One-cycle pulse when the active flag clears |
| walk_ptr_o | output | 32 | Walker fetch pointer, loaded from the base on each start |
| dir_o | output | 1 | Transfer direction (command bit 3) |
| drv_irq_i | input | 1 | Drive interrupt level |
| host_irq_o | output | 1 | Host interrupt |

## Verification
The start bit is driven with rising, falling and repeated values. This separates an edge-triggered command from a level-triggered one and shows whether a repeated write leaks a kick or a stop. The start bit is also cleared with the walker busy and with the walker idle, and raised again during a pending stop, which separates a stop that waits for completion from one that aborts and shows whether a restart re-kicks the walker. The base register is written and read at every size and at unaligned lanes. This catches wrong lane masks, data that is not right-aligned and low address bits that are not forced to zero. The interrupt input is toggled around W1C writes to show that the flag is sticky, that the line passes straight through and that a set wins over a clear in the same cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NLANE  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(NLANE);
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;

  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_DIR   = 3;
  localparam int unsigned ST_ACT    = 0;
  localparam int unsigned ST_IRQ    = 2;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} acc_size_e;

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    width_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_H:    width_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: width_mask = '1;
    endcase
  endfunction

  function automatic logic [NLANE-1:0] lane_en(input logic [1:0] sz, input logic [LANE_W-1:0] lane);
    logic [NLANE-1:0] base;
    case (sz)
      SZ_B:    base = {{(NLANE-1){1'b0}}, 1'b1};
      SZ_H:    base = {{(NLANE-2){1'b0}}, 2'b11};
      default: base = '1;
    endcase
    lane_en = base << lane;
  endfunction
endpackage

// File: rtl/bmdma_cmd_ctrl.sv
module bmdma_cmd_ctrl
  import bmdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              start_bit_i,
  input  logic              dir_bit_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              walk_busy_i,
  output logic              start_q_o,
  output logic              dir_q_o,
  output logic              active_o,
  output logic              walk_start_o,
  output logic              walk_stop_o,
  output logic [DATA_W-1:0] walk_ptr_o
);
  logic start_q, dir_q, active_q, stop_pend_q, kick_q, stop_q;
  logic [DATA_W-1:0] ptr_q;
  logic toggle, rise, fall;

  assign toggle = cmd_wr_i && (start_bit_i != start_q);
  assign rise   = toggle && start_bit_i;
  assign fall   = toggle && !start_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q     <= 1'b0;
      dir_q       <= 1'b0;
      active_q    <= 1'b0;
      stop_pend_q <= 1'b0;
      kick_q      <= 1'b0;
      stop_q      <= 1'b0;
      ptr_q       <= '0;
    end else begin
      kick_q <= 1'b0;
      stop_q <= 1'b0;
      if (cmd_wr_i) begin
        start_q <= start_bit_i;
        dir_q   <= dir_bit_i;
      end
      if (rise) begin
        ptr_q       <= base_i;
        stop_pend_q <= 1'b0;
        if (!active_q) begin
          active_q <= 1'b1;
          kick_q   <= 1'b1;
        end
      end else if (fall) begin
        // let an in-flight transfer drain instead of cutting it
        if (walk_busy_i) begin
          stop_pend_q <= active_q;
        end else begin
          active_q <= 1'b0;
          stop_q   <= active_q;
        end
      end else if (stop_pend_q && !walk_busy_i) begin
        stop_pend_q <= 1'b0;
        active_q    <= 1'b0;
        stop_q      <= 1'b1;
      end
    end
  end

  assign start_q_o    = start_q;
  assign dir_q_o      = dir_q;
  assign active_o     = active_q;
  assign walk_start_o = kick_q;
  assign walk_stop_o  = stop_q;
  assign walk_ptr_o   = ptr_q;
endmodule

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg
  import bmdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] rd_o
);
  logic [NLANE-1:0]  be;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] base_q;

  assign be      = wr_i ? lane_en(size_i, lane_i) : '0;
  assign shifted = wdata_i << {lane_i, 3'b000};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    if (g == 0) begin : g_low
      // table pointer is dword aligned
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   base_q[7:0] <= '0;
        else if (be[0]) base_q[7:0] <= {shifted[7:2], 2'b00};
      end
    end else begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   base_q[g*8 +: 8] <= '0;
        else if (be[g]) base_q[g*8 +: 8] <= shifted[g*8 +: 8];
      end
    end
  end

  assign base_o = base_q;
  assign rd_o   = (base_q >> {lane_i, 3'b000}) & width_mask(size_i);
endmodule

// File: rtl/bmdma_irq_stat.sv
module bmdma_irq_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_irq_i,
  input  logic clr_i,
  output logic irq_flag_o,
  output logic host_irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (drv_irq_i) flag_q <= 1'b1;
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign irq_flag_o = flag_q;
  assign host_irq_o = drv_irq_i;
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [1:0]        reg_size_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              walk_busy_i,
  output logic              walk_start_o,
  output logic              walk_stop_o,
  output logic [DATA_W-1:0] walk_ptr_o,
  output logic              dir_o,
  input  logic              drv_irq_i,
  output logic              host_irq_o
);
  logic              cmd_wr, stat_wr, base_sel;
  logic              start_q, dir_q, active, irq_flag;
  logic [DATA_W-1:0] base_q, base_rd;

  assign cmd_wr   = reg_wr_i && (reg_addr_i == OFF_CMD);
  assign stat_wr  = reg_wr_i && (reg_addr_i == OFF_STAT);
  assign base_sel = reg_addr_i[ADDR_W-1];

  bmdma_cmd_ctrl u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr),
    .start_bit_i  (reg_wdata_i[CMD_START]),
    .dir_bit_i    (reg_wdata_i[CMD_DIR]),
    .base_i       (base_q),
    .walk_busy_i  (walk_busy_i),
    .start_q_o    (start_q),
    .dir_q_o      (dir_q),
    .active_o     (active),
    .walk_start_o (walk_start_o),
    .walk_stop_o  (walk_stop_o),
    .walk_ptr_o   (walk_ptr_o)
  );

  bmdma_base_reg u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i && base_sel),
    .lane_i  (reg_addr_i[LANE_W-1:0]),
    .size_i  (reg_size_i),
    .wdata_i (reg_wdata_i),
    .base_o  (base_q),
    .rd_o    (base_rd)
  );

  bmdma_irq_stat u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drv_irq_i  (drv_irq_i),
    .clr_i      (stat_wr && reg_wdata_i[ST_IRQ]),
    .irq_flag_o (irq_flag),
    .host_irq_o (host_irq_o)
  );

  assign dir_o = dir_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (base_sel) begin
        reg_rdata_o = base_rd;
      end else if (reg_addr_i == OFF_CMD) begin
        reg_rdata_o[CMD_START] = start_q;
        reg_rdata_o[CMD_DIR]   = dir_q;
      end else if (reg_addr_i == OFF_STAT) begin
        reg_rdata_o[ST_ACT] = active;
        reg_rdata_o[ST_IRQ] = irq_flag;
      end
    end
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk
  import bmdma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [1:0]        reg_size_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              walk_busy_i,
  input logic              walk_start_o,
  input logic [DATA_W-1:0] walk_ptr_o,
  input logic              drv_irq_i,
  input logic              start_q,
  input logic              active,
  input logic              irq_flag,
  input logic [DATA_W-1:0] base_q
);
  logic cmd_wr;
  assign cmd_wr = reg_wr_i && (reg_addr_i == OFF_CMD);

  a_r1_same_start_no_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[CMD_START] == start_q) |=> !walk_start_o);

  a_r2_kick_loads_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_start_o |-> (active && walk_ptr_o == base_q));

  a_r3_clear_waits_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active) |-> !$past(walk_busy_i));

  a_r4_no_kick_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[CMD_START] && active) |=> !walk_start_o);

  a_r7_base_read_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 3'd4 && reg_size_i == 2'd2) |-> reg_rdata_o[1:0] == 2'b00);

  a_r8_irq_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_irq_i |=> irq_flag);

  a_r8_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_irq_i && !(reg_wr_i && reg_addr_i == OFF_STAT)) |=> $stable(irq_flag));
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_size_i  (reg_size_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .walk_busy_i (walk_busy_i),
  .walk_start_o(walk_start_o),
  .walk_ptr_o  (walk_ptr_o),
  .drv_irq_i   (drv_irq_i),
  .start_q     (start_q),
  .active      (active),
  .irq_flag    (irq_flag),
  .base_q      (base_q)
);

// File: tb/bmdma_regs_bench.sv
`timescale 1ns/1ps
module bmdma_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [1:0]  reg_size_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        walk_busy_i = 1'b0;
  logic        walk_start_o, walk_stop_o, dir_o, host_irq_o;
  logic [31:0] walk_ptr_o;
  logic        drv_irq_i = 1'b0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bmdma_regs u_bmdma_regs (.*);

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'h0},        // R10 cmd after reset
    '{1'b1, 3'd4, 2'd2, 32'hDEADBEEF, 32'h0},
    '{1'b0, 3'd4, 2'd2, 32'h0,        32'hDEADBEEC}, // R6 low bits forced
    '{1'b1, 3'd5, 2'd0, 32'h12,       32'h0},
    '{1'b0, 3'd5, 2'd0, 32'h0,        32'h12},       // R7 byte lane 1
    '{1'b0, 3'd4, 2'd1, 32'h0,        32'h12EC},     // R6 only lane 1 touched
    '{1'b1, 3'd6, 2'd1, 32'hA5A7,     32'h0},
    '{1'b0, 3'd6, 2'd1, 32'h0,        32'hA5A7},     // R7 half at lane 2
    '{1'b0, 3'd4, 2'd2, 32'h0,        32'hA5A712EC}, // R6
    '{1'b1, 3'd4, 2'd0, 32'hFF,       32'h0},
    '{1'b0, 3'd4, 2'd0, 32'h0,        32'hFC},       // R6 byte write lane 0
    '{1'b1, 3'd0, 2'd0, 32'hF6,       32'h0},
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'h0},        // R5 only bits 0,3 kept
    '{1'b0, 3'd2, 2'd0, 32'h0,        32'h0}         // R8 status idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_size_i = s; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a; reg_size_i = s;
    #1 d = reg_rdata_o;
    reg_rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    chk("R10 ptr", walk_ptr_o, 32'h0);
    chk("R10 kick", {30'b0, walk_start_o, walk_stop_o}, 32'h0);
    rd(3'd4, 2'd2, d); chk("R10 base", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].size, VECS[i].data);
      else begin
        rd(VECS[i].addr, VECS[i].size, d);
        chk($sformatf("R5/R6/R7 vec%0d", i), d, VECS[i].exp);
      end
    end
    chk("R5 dir_o low", {31'b0, dir_o}, 32'h0);

    // R2 kick
    wr(3'd0, 2'd0, 32'h09);
    chk("R2 kick", {31'b0, walk_start_o}, 32'h1);
    chk("R2 ptr", walk_ptr_o, 32'hA5A712FC);
    chk("R5 dir_o", {31'b0, dir_o}, 32'h1);
    idle(1);
    chk("R2 single pulse", {31'b0, walk_start_o}, 32'h0);
    rd(3'd2, 2'd0, d); chk("R2 active", d, 32'h1);

    // R1 rewrite same start
    wr(3'd0, 2'd0, 32'h01);
    chk("R1 no rekick", {30'b0, walk_start_o, walk_stop_o}, 32'h0);
    rd(3'd2, 2'd0, d); chk("R1 active kept", d, 32'h1);

    // R3 stop while busy
    walk_busy_i = 1'b1;
    wr(3'd0, 2'd0, 32'h00);
    chk("R3 no stop while busy", {31'b0, walk_stop_o}, 32'h0);
    idle(3);
    rd(3'd2, 2'd0, d); chk("R3 active held", d, 32'h1);
    @(negedge clk_i); walk_busy_i = 1'b0;
    @(negedge clk_i);
    chk("R3 stop pulse", {31'b0, walk_stop_o}, 32'h1);
    rd(3'd2, 2'd0, d); chk("R3 active cleared", d, 32'h0);

    // R1 rewrite 0 when idle
    wr(3'd0, 2'd0, 32'h00);
    chk("R1 idle rewrite", {30'b0, walk_start_o, walk_stop_o}, 32'h0);

    // R3 stop when idle walker
    wr(3'd0, 2'd0, 32'h01);
    wr(3'd0, 2'd0, 32'h00);
    chk("R3 immediate stop", {31'b0, walk_stop_o}, 32'h1);
    rd(3'd2, 2'd0, d); chk("R3 immediate clear", d, 32'h0);

    // R4 restart during pending stop
    wr(3'd0, 2'd0, 32'h01);
    walk_busy_i = 1'b1;
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd4, 2'd2, 32'h00000100);
    wr(3'd0, 2'd0, 32'h01);
    chk("R4 no kick", {31'b0, walk_start_o}, 32'h0);
    chk("R4 ptr reload", walk_ptr_o, 32'h100);
    @(negedge clk_i); walk_busy_i = 1'b0;
    idle(2);
    chk("R4 no stop", {31'b0, walk_stop_o}, 32'h0);
    rd(3'd2, 2'd0, d); chk("R4 still active", d, 32'h1);

    // R8 / R9 interrupt
    @(negedge clk_i); drv_irq_i = 1'b1;
    #1 chk("R8 passthrough hi", {31'b0, host_irq_o}, 32'h1);
    @(negedge clk_i); drv_irq_i = 1'b0;
    #1 chk("R8 passthrough lo", {31'b0, host_irq_o}, 32'h0);
    rd(3'd2, 2'd0, d); chk("R8 sticky flag", d, 32'h5);
    wr(3'd2, 2'd0, 32'h01);
    rd(3'd2, 2'd0, d); chk("R9 active read-only", d, 32'h5);
    drv_irq_i = 1'b1;
    wr(3'd2, 2'd0, 32'h04);
    drv_irq_i = 1'b0;
    rd(3'd2, 2'd0, d); chk("R9 set wins", d, 32'h5);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, d); chk("R9 w1c", d, 32'h1);

    // R10 reset mid-activity
    @(negedge clk_i); drv_irq_i = 1'b1;
    @(negedge clk_i); drv_irq_i = 1'b0; rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    rd(3'd2, 2'd0, d); chk("R10 status", d, 32'h0);
    rd(3'd0, 2'd0, d); chk("R10 cmd", d, 32'h0);
    rd(3'd4, 2'd2, d); chk("R10 base cleared", d, 32'h0);
    chk("R10 ptr cleared", walk_ptr_o, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule